// File: doc/BRIEF.md
# Round-Robin Time Partition Scheduler

This block hands a processor out to a set of partitions in fixed time slices. A schedule table of eight entries pairs a partition number with a slice length counted in ticks. The block walks the table in index order and wraps from the last entry back to the first. An entry whose slice length is zero is passed over. While a slice runs, the counter drops by one on each tick. When the counter reaches zero, the block closes the slice with a fixed switch sequence. It first drops the interrupt enable. It then asks the core to save the outgoing partition's context, and moves the current-partition register to the next scheduled partition. Last, it asks the core to load that partition's context. Interrupts are enabled again only after the load is acknowledged.

Interrupt request lines carry the number of the partition they target. Each request sets a pending bit for its own line and partition. Pending bits are delivered only to the partition that is running, and only while interrupts are enabled. This covers a request that arrives during a switch. It also covers a request for a partition that is waiting for its slot, which is delivered when that slot opens. The processor core and the context storage lie outside the block. The block only raises the save and load requests and waits for their acknowledges.

Top module: `tpart_sched`

## Requirements
- R1: While reset is applied and on the first cycle after it, `cur_valid`, `irq_en`, `save_req`, `load_req` and `irq_dlv` are all 0.
- R2: Slots are granted in rising table index order and wrap from index 7 to index 0. The partition number of the granted entry appears on `cur_pid` in the same cycle that `load_req` rises.
- R3: An entry whose tick field is 0 is never granted. The search checks one entry per clock. If every entry is 0, `cur_valid` stays 0.
- R4: A granted slot keeps `irq_en` high for exactly as many `tick` pulses as its entry's tick field holds. The cycle after the last counted tick, `irq_en` is 0 and `save_req` is 1.
- R5: The switch runs in this order: `irq_en` falls, then `save_req` is held until `save_ack`, then `cur_pid` changes, then `load_req` is held until `load_ack`, then `irq_en` rises. `cur_pid` never changes while `save_req` is high.
- R6: The first grant after reset raises `load_req` without any `save_req` before it.
- R7: `tick` pulses that fall while `irq_en` is 0 do not shorten any slot.
- R8: A request on line i with target partition p (bits i*3+2..i*3 of `irq_pid`) is delivered on `irq_dlv[i]` only while p is current and `irq_en` was 1 in the previous cycle. A request for a partition that is never granted is never delivered.
- R9: A request for the current partition made while `irq_en` is 0 is kept. It is delivered after `irq_en` returns to 1.
- R10: Each delivery is a single-cycle pulse and clears that pending bit. Several requests for the same line and partition before delivery produce one pulse.
- R11: Writing a table entry during a slot does not change the length of the running slot. The new value applies when that entry is next granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Time base pulse, counted only while a slot runs |
| tbl_we | input | 1 | Schedule table write strobe |
| tbl_idx | input | 3 | Table entry to write |
| tbl_pid | input | 3 | Partition number for the entry |
| tbl_ticks | input | 16 | Slot length in ticks; 0 disables the entry |
| irq_req | input | 4 | One request pulse per interrupt line |
| irq_pid | input | 12 | Target partition per line, 3 bits per line, line 0 in the low bits |
| save_req | output | 1 | Request to the core to save the outgoing context |
| save_ack | input | 1 | Core has finished the save |
| load_req | output | 1 | Request to the core to load the context named by `cur_pid` |
| load_ack | input | 1 | Core has finished the load |
| cur_pid | output | 3 | Current partition |
| cur_valid | output | 1 | A partition has been granted since reset |
| irq_en | output | 1 | Interrupt enable, high only while a slot runs |
| irq_dlv | output | 4 | Delivered interrupt pulses for the current partition |

## Verification
Every cycle, the assertions check the local rules of the switch sequence. These are that a save or load request is held until it is acknowledged, that the partition register changes only on entry to the load phase, that a running slot never holds a zero count, that a slot is left only on a tick, and that no interrupt is delivered while interrupts are disabled. Some properties cover the whole schedule, and only the bench scenarios can show them. These are the grant order around the table with zero entries skipped, the exact slot lengths including a length rewritten mid-slot, and the holding of an interrupt across other partitions' slots until its owner returns, with repeated requests merged.

// File: rtl/tps_pkg.sv
package tps_pkg;

  typedef enum logic [1:0] {
    PH_SEEK = 2'd0,
    PH_LOAD = 2'd1,
    PH_RUN  = 2'd2,
    PH_SAVE = 2'd3
  } phase_t;

endpackage

// File: rtl/tps_table.sv
module tps_table #(
  parameter int N_ENTRY = 8,
  parameter int PID_W   = 3,
  parameter int TICK_W  = 16,
  localparam int IDX_W  = $clog2(N_ENTRY)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [IDX_W-1:0]  waddr,
  input  logic [PID_W-1:0]  wpid,
  input  logic [TICK_W-1:0] wticks,
  input  logic [IDX_W-1:0]  raddr,
  output logic [PID_W-1:0]  rpid,
  output logic [TICK_W-1:0] rticks
);

  logic [N_ENTRY-1:0][PID_W-1:0]  pid_q;
  logic [N_ENTRY-1:0][TICK_W-1:0] len_q;

  for (genvar e = 0; e < N_ENTRY; e++) begin : g_ent
    logic hit;
    assign hit = we && (waddr == IDX_W'(e));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pid_q[e] <= '0;
        len_q[e] <= '0;
      end else if (hit) begin
        pid_q[e] <= wpid;
        len_q[e] <= wticks;
      end
    end
  end

  assign rpid   = pid_q[raddr];
  assign rticks = len_q[raddr];

endmodule

// File: rtl/tps_slot_ctrl.sv
module tps_slot_ctrl
  import tps_pkg::*;
#(
  parameter int N_ENTRY = 8,
  parameter int PID_W   = 3,
  parameter int TICK_W  = 16,
  localparam int IDX_W  = $clog2(N_ENTRY)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              save_ack,
  input  logic              load_ack,
  input  logic [PID_W-1:0]  ent_pid,
  input  logic [TICK_W-1:0] ent_ticks,
  output logic [IDX_W-1:0]  rd_idx,
  output phase_t            phase,
  output logic [PID_W-1:0]  cur_pid,
  output logic              cur_valid,
  output logic              ev_found,
  output logic              ev_expire
);

  logic [TICK_W-1:0] cnt_q;

  function automatic logic [IDX_W-1:0] next_idx(input logic [IDX_W-1:0] i);
    return (i == IDX_W'(N_ENTRY - 1)) ? '0 : i + 1'b1;
  endfunction

  function automatic logic last_tick(input logic [TICK_W-1:0] c);
    return c == TICK_W'(1);
  endfunction

  assign ev_found  = (phase == PH_SEEK) && (ent_ticks != '0);
  assign ev_expire = (phase == PH_RUN) && tick && last_tick(cnt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_SEEK;
      rd_idx    <= '0;
      cur_pid   <= '0;
      cur_valid <= 1'b0;
      cnt_q     <= '0;
    end else begin
      unique case (phase)
        PH_SEEK: begin
          rd_idx <= next_idx(rd_idx);
          if (ev_found) begin
            cur_pid   <= ent_pid;
            cnt_q     <= ent_ticks;
            cur_valid <= 1'b1;
            phase     <= PH_LOAD;
          end
        end
        PH_LOAD: if (load_ack) phase <= PH_RUN;
        PH_RUN: begin
          if (ev_expire) begin
            cnt_q <= '0;
            phase <= PH_SAVE;
          end else if (tick) begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        PH_SAVE: if (save_ack) phase <= PH_SEEK;
        default: phase <= PH_SEEK;
      endcase
    end
  end

  // R5: a save request is held until it is acknowledged
  a_r5_hold_save: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_SAVE && !save_ack) |=> phase == PH_SAVE);

  // R5: a load request is held until it is acknowledged
  a_r5_hold_load: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_LOAD && !load_ack) |=> phase == PH_LOAD);

  // R5: the partition register moves only on entry to the load phase
  a_r5_pid_move: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_pid != $past(cur_pid)) |-> phase == PH_LOAD);

  // R5: the partition register is frozen across the save handshake
  a_r5_pid_in_save: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_SAVE) |=> $stable(cur_pid));

  // R4: a running slot never holds an exhausted count
  a_r4_live_count: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_RUN) |-> cnt_q != '0);

  // R7: a slot is left only on a tick
  a_r7_exit_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_RUN && !tick) |=> (phase == PH_RUN && $stable(cnt_q)));

  // R6: nothing is saved before the first grant
  a_r6_no_early_save: assert property (@(posedge clk) disable iff (!rst_n)
    !cur_valid |-> phase != PH_SAVE);

endmodule

// File: rtl/tps_irq_pend.sv
module tps_irq_pend #(
  parameter int PID_W = 3,
  parameter int N_IRQ = 4,
  localparam int N_PART = 1 << PID_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [N_IRQ-1:0]       irq_req,
  input  logic [N_IRQ*PID_W-1:0] irq_pid,
  input  logic                   deliver_en,
  input  logic [PID_W-1:0]       cur_pid,
  output logic [N_IRQ-1:0]       irq_dlv
);

  logic [N_PART-1:0][N_IRQ-1:0] pend_q, set_m, clr_m;
  logic [N_IRQ-1:0]             fire;

  for (genvar i = 0; i < N_IRQ; i++) begin : g_line
    assign fire[i] = deliver_en && pend_q[cur_pid][i];
    for (genvar p = 0; p < N_PART; p++) begin : g_part
      assign set_m[p][i] = irq_req[i] && (irq_pid[i*PID_W +: PID_W] == PID_W'(p));
      assign clr_m[p][i] = fire[i] && (cur_pid == PID_W'(p));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= '0;
      irq_dlv <= '0;
    end else begin
      pend_q  <= (pend_q & ~clr_m) | set_m;
      irq_dlv <= fire;
    end
  end

  // R8: nothing is delivered after a cycle with interrupts disabled
  a_r8_quiet_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !deliver_en |=> irq_dlv == '0);

  // R10: a delivery without a fresh request is not repeated
  a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (fire[0] && !irq_req[0] && $stable(cur_pid)) |=> !fire[0] || !$stable(cur_pid));

endmodule

// File: rtl/tpart_sched.sv
module tpart_sched
  import tps_pkg::*;
#(
  parameter int N_ENTRY = 8,
  parameter int PID_W   = 3,
  parameter int TICK_W  = 16,
  parameter int N_IRQ   = 4,
  localparam int IDX_W  = $clog2(N_ENTRY)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   tick,
  input  logic                   tbl_we,
  input  logic [IDX_W-1:0]       tbl_idx,
  input  logic [PID_W-1:0]       tbl_pid,
  input  logic [TICK_W-1:0]      tbl_ticks,
  input  logic [N_IRQ-1:0]       irq_req,
  input  logic [N_IRQ*PID_W-1:0] irq_pid,
  output logic                   save_req,
  input  logic                   save_ack,
  output logic                   load_req,
  input  logic                   load_ack,
  output logic [PID_W-1:0]       cur_pid,
  output logic                   cur_valid,
  output logic                   irq_en,
  output logic [N_IRQ-1:0]       irq_dlv
);

  phase_t             phase;
  logic [IDX_W-1:0]   rd_idx;
  logic [PID_W-1:0]   ent_pid;
  logic [TICK_W-1:0]  ent_ticks;
  logic               ev_found, ev_expire;

  tps_table #(.N_ENTRY(N_ENTRY), .PID_W(PID_W), .TICK_W(TICK_W)) u_table (
    .clk(clk), .rst_n(rst_n), .we(tbl_we), .waddr(tbl_idx), .wpid(tbl_pid),
    .wticks(tbl_ticks), .raddr(rd_idx), .rpid(ent_pid), .rticks(ent_ticks)
  );

  tps_slot_ctrl #(.N_ENTRY(N_ENTRY), .PID_W(PID_W), .TICK_W(TICK_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .tick(tick), .save_ack(save_ack), .load_ack(load_ack),
    .ent_pid(ent_pid), .ent_ticks(ent_ticks), .rd_idx(rd_idx), .phase(phase),
    .cur_pid(cur_pid), .cur_valid(cur_valid), .ev_found(ev_found), .ev_expire(ev_expire)
  );

  assign irq_en   = (phase == PH_RUN);
  assign save_req = (phase == PH_SAVE);
  assign load_req = (phase == PH_LOAD);

  tps_irq_pend #(.PID_W(PID_W), .N_IRQ(N_IRQ)) u_pend (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_pid(irq_pid),
    .deliver_en(irq_en), .cur_pid(cur_pid), .irq_dlv(irq_dlv)
  );

  // R4: the expiring tick is followed at once by the save request
  a_r4_expire_to_save: assert property (@(posedge clk) disable iff (!rst_n)
    ev_expire |=> (save_req && !irq_en));

  // R2: a found entry raises the load request on the next cycle
  a_r2_found_to_load: assert property (@(posedge clk) disable iff (!rst_n)
    ev_found |=> load_req);

endmodule

// File: tb/test_tpart_sched.sv
module test_tpart_sched;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        tbl_we = 1'b0;
  logic [2:0]  tbl_idx = '0;
  logic [2:0]  tbl_pid = '0;
  logic [15:0] tbl_ticks = '0;
  logic [3:0]  irq_req = '0;
  logic [11:0] irq_pid = '0;
  logic        save_req, load_req, cur_valid, irq_en;
  logic        save_ack = 1'b0, load_ack = 1'b0;
  logic [2:0]  cur_pid;
  logic [3:0]  irq_dlv;

  always #5 clk = ~clk;

  tpart_sched i_tpart_sched (
    .clk(clk), .rst_n(rst_n), .tick(tick), .tbl_we(tbl_we), .tbl_idx(tbl_idx),
    .tbl_pid(tbl_pid), .tbl_ticks(tbl_ticks), .irq_req(irq_req), .irq_pid(irq_pid),
    .save_req(save_req), .save_ack(save_ack), .load_req(load_req), .load_ack(load_ack),
    .cur_pid(cur_pid), .cur_valid(cur_valid), .irq_en(irq_en), .irq_dlv(irq_dlv)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d @%0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int m_tp[8], m_tt[8];
  int m_phase;      // 0 searching, 1 loading, 2 running, 3 saving
  int m_ptr, m_pid, m_left;
  bit m_valid;
  bit m_pend[8][4];
  bit m_dlv[4];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < 8; k++) begin
        m_tp[k] = 0; m_tt[k] = 0;
        for (int j = 0; j < 4; j++) m_pend[k][j] = 0;
      end
      m_phase = 0; m_ptr = 0; m_pid = 0; m_left = 0; m_valid = 0;
      for (int j = 0; j < 4; j++) m_dlv[j] = 0;
    end else begin
      bit give[4];
      for (int j = 0; j < 4; j++) give[j] = (m_phase == 2) && m_pend[m_pid][j];
      for (int j = 0; j < 4; j++) begin
        if (give[j]) m_pend[m_pid][j] = 0;
        if (irq_req[j]) m_pend[irq_pid[j*3 +: 3]][j] = 1;
        m_dlv[j] = give[j];
      end
      case (m_phase)
        0: begin
          if (m_tt[m_ptr] != 0) begin
            m_pid = m_tp[m_ptr]; m_left = m_tt[m_ptr]; m_valid = 1; m_phase = 1;
          end
          m_ptr = (m_ptr + 1) % 8;
        end
        1: if (load_ack) m_phase = 2;
        2: if (tick) begin
             m_left = m_left - 1;
             if (m_left == 0) m_phase = 3;
           end
        default: if (save_ack) m_phase = 0;
      endcase
      if (tbl_we) begin
        m_tp[tbl_idx] = tbl_pid; m_tt[tbl_idx] = tbl_ticks;
      end
    end
  end

  // ---------------- bench-side schedule bookkeeping ----------------
  int b_pid[8], b_len[8];
  int b_last = -1;
  bit prev_en = 0;
  int run_cnt = 0, exp_len = 0, slot_pid = 0, n_slots = 0;
  int dcnt[8][4];
  int cyc = 0, sdly = 0, ldly = 0;
  bit seen_save = 0;

  function automatic int next_live(input int from);
    for (int s = 1; s <= 8; s++)
      if (b_len[(from + s) % 8] != 0) return (from + s) % 8;
    return -1;
  endfunction

  function automatic int idx_of_pid(input int p);
    for (int k = 0; k < 8; k++) if (b_len[k] != 0 && b_pid[k] == p) return k;
    return -1;
  endfunction

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      // per-cycle comparison with the model
      check(cur_valid == m_valid, "R6 cur_valid", cur_valid, m_valid);
      check(cur_pid == 3'(m_pid), "R2 cur_pid", cur_pid, m_pid);
      check(irq_en == (m_phase == 2), "R5 irq_en", irq_en, m_phase == 2);
      check(save_req == (m_phase == 3), "R5 save_req", save_req, m_phase == 3);
      check(load_req == (m_phase == 1), "R5 load_req", load_req, m_phase == 1);
      for (int j = 0; j < 4; j++)
        check(irq_dlv[j] == m_dlv[j], "R8 irq_dlv", irq_dlv[j], m_dlv[j]);
      if (save_req) seen_save = 1;
      if (load_req && !seen_save && n_slots == 0)
        check(1, "R6 first grant without save", 0, 0);
      for (int j = 0; j < 4; j++) if (irq_dlv[j]) dcnt[cur_pid][j]++;
      // slot boundaries
      if (irq_en && !prev_en) begin
        int want;
        slot_pid = cur_pid;
        if (b_last < 0) want = idx_of_pid(cur_pid);
        else want = next_live(b_last);
        check(want >= 0 && b_pid[want] == cur_pid, "R2 R3 grant order", cur_pid,
              (want >= 0) ? b_pid[want] : -1);
        if (want >= 0) begin
          b_last = want;
          exp_len = b_len[want];
        end
        run_cnt = 0;
      end
      if (!irq_en && prev_en) begin
        n_slots++;
        check(run_cnt == exp_len && save_req, "R4 R7 R11 slot length", run_cnt, exp_len);
      end
      prev_en = irq_en;
      // core handshake responder
      if (save_req && !save_ack) sdly++; else sdly = 0;
      save_ack = (sdly == 2);
      if (load_req && !load_ack) ldly++; else ldly = 0;
      load_ack = (ldly == 3);
    end
    tick = (cyc % 3 == 0);
    if (rst_n && irq_en && tick) run_cnt++;
  end

  // ---------------- stimulus ----------------
  task automatic wr(input int k, input int p, input int t);
    @(negedge clk);
    tbl_we = 1; tbl_idx = 3'(k); tbl_pid = 3'(p); tbl_ticks = 16'(t);
    b_pid[k] = p; b_len[k] = t;
    @(negedge clk);
    tbl_we = 0;
  endtask

  task automatic raise(input int line, input int p);
    @(negedge clk);
    irq_req[line] = 1; irq_pid[line*3 +: 3] = 3'(p);
    @(negedge clk);
    irq_req[line] = 0;
  endtask

  task automatic wait_run(input int p);
    do @(negedge clk); while (!(irq_en && cur_pid == 3'(p)));
  endtask

  initial begin
    for (int k = 0; k < 8; k++) begin
      b_pid[k] = 0; b_len[k] = 0;
      for (int j = 0; j < 4; j++) dcnt[k][j] = 0;
    end
    repeat (3) @(negedge clk);
    // R1: outputs quiet during reset
    check(!cur_valid && !irq_en && !save_req && !load_req && irq_dlv == 0,
          "R1 reset outputs", {cur_valid, irq_en, save_req, load_req}, 0);
    rst_n = 1;
    @(negedge clk);
    check(!cur_valid && !irq_en && !save_req && !load_req && irq_dlv == 0,
          "R1 after reset", {cur_valid, irq_en, save_req, load_req}, 0);
    repeat (20) @(negedge clk);
    // R3: empty table grants nothing
    check(!cur_valid && !load_req, "R3 empty table", cur_valid, 0);
    wr(0, 2, 3);
    wr(1, 5, 0);
    wr(2, 1, 2);
    wr(7, 6, 1);
    // R8 R10: line 0 for partition 6 raised twice during partition 2
    wait_run(2);
    raise(0, 6);
    raise(0, 6);
    raise(2, 5);
    check(dcnt[6][0] == 0, "R8 held while owner idle", dcnt[6][0], 0);
    // R9: request for incoming partition during load
    do @(negedge clk); while (!(load_req && cur_pid == 3'd1));
    check(!irq_en, "R9 irq_en low during load", irq_en, 0);
    raise(1, 1);
    wait_run(6);
    do @(negedge clk); while (irq_en);
    check(dcnt[6][0] == 1, "R8 R10 one delivery to owner", dcnt[6][0], 1);
    check(dcnt[1][1] == 1, "R9 held request delivered", dcnt[1][1], 1);
    // R11: rewrite running entry mid-slot
    wait_run(2);
    wr(0, 2, 5);
    repeat (400) @(negedge clk);
    check(dcnt[5][2] == 0, "R8 never-granted target", dcnt[5][2], 0);
    check(n_slots >= 10, "R2 slots granted", n_slots, 10);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog R2 actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule